// File: doc/BRIEF.md
# Response Port with Retry Handshake

This block is the adapter that sits between one requester and a shared resource that serves one request at a time. Requests and responses both travel in single-cycle attempts. The receiving side takes an attempt or refuses it in the same cycle, and there is no waiting valid/ready backpressure. When the adapter refuses a request, it owes the requester a retry notification. When the requester refuses a response, the adapter parks that response in a one-entry slot. It resends the response when the requester signals, through a separate input, that it can take responses again.

A retry notification is a one-cycle pulse on `retry_o`. It is raised only at a check point, and only if a retry is owed and the slot has drained. There are two check points. The first is the shared resource's completion strobe `resp_done_i`, which the resource sends to every port after each response it delivers. The second is this port's own resend of a parked response. A request arriving in the same cycle as the pulse is judged with the owed flag already cleared. The controller has four states, named after the two bits of port state:

- `ST_FREE`: nothing is parked and no retry is owed.
- `ST_OWED`: a retry is owed and the slot is empty.
- `ST_HELD`: a response is parked and no retry is owed.
- `ST_HELD_OWED`: both are true.

The transitions are these. A refused request adds "owed". A refused response adds "held". A resend that the requester takes removes "held". A pulse removes "owed". The state for the next cycle is always formed from the post-cycle held and owed bits.

Top module: `retry_resp_port`

## Requirements
- R1: After reset the port is in ST_FREE. `retry_o` is low, and with idle inputs neither `fwd_valid_o` nor `rsp_valid_o` is raised.
- R2: While a response is parked, or a retry is owed, an incoming request is refused. Both `req_accept_o` and `fwd_valid_o` stay low, and a retry becomes owed.
- R3: If the resource refuses a forwarded request (`fwd_accept_i` low), the request is refused toward the requester and a retry becomes owed.
- R4: A response that the requester refuses is parked. A later `rsp_retry_i` presents the parked data on `rsp_data_o`. A `rsp_retry_i` with an empty slot produces no response.
- R5: If a resend is refused again, the response stays parked with its data unchanged.
- R6: `retry_o` pulses for one cycle only at a check point (`resp_done_i` high, or a resend cycle), only if a retry is owed, and only if the slot is empty after that cycle. The pulse clears the owed flag, so an immediate second check point gives no pulse.
- R7: A request presented in the same cycle as a `retry_o` pulse is judged with the owed flag cleared, so it is forwarded and can be accepted.
- R8: The resource never presents a new response (`rsp_valid_i`) while the slot is occupied. This is an environment rule and is checked as an assertion.
- R9: A request that is not blocked is forwarded with its payload unchanged. A new response, when the slot is empty, passes straight to `rsp_data_o` in the same cycle.
- R10: If a check point arrives while a retry is owed but the slot is full, no pulse is sent. A resend that the requester takes then releases the pulse in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Requester presents a request this cycle |
| req_data_i | input | REQ_W | Request payload |
| req_accept_o | output | 1 | Request taken this cycle (low means refused) |
| fwd_valid_o | output | 1 | Request forwarded to the shared resource |
| fwd_data_o | output | REQ_W | Forwarded payload |
| fwd_accept_i | input | 1 | Resource takes the forwarded request |
| rsp_valid_i | input | 1 | Resource delivers a new response |
| rsp_data_i | input | RSP_W | New response data |
| rsp_valid_o | output | 1 | Response attempt toward the requester |
| rsp_data_o | output | RSP_W | Response data toward the requester |
| rsp_accept_i | input | 1 | Requester takes the response (low means refused) |
| rsp_retry_i | input | 1 | Requester can take a parked response again |
| resp_done_i | input | 1 | Shared resource finished a response delivery (check point) |
| retry_o | output | 1 | One-cycle retry notification to the requester |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Slot drains in the same cycle a request arrives.** A resend is accepted in the very cycle that a new request arrives. A design that judged the request against the old held or owed state would refuse it and lose the R7 forwarding.
- **Check point while the slot is full.** A completion strobe arrives while a retry is owed but a response is still parked. A design that ignored the slot would pulse early and invite a request it must then refuse.
- **Repeated refusal of a resend.** A parked response is refused a second time. A design that dropped the slot on resend would lose the data.
- **Back-to-back check points.** Two check points follow each other. A design that did not clear the owed flag would emit a second, spurious pulse.
- **Stray resend signal.** A `rsp_retry_i` arrives with nothing parked. It must not create a phantom response.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

    // Encoding: bit 1 = response parked, bit 0 = retry owed
    typedef enum logic [1:0] {
        ST_FREE      = 2'b00,
        ST_OWED      = 2'b01,
        ST_HELD      = 2'b10,
        ST_HELD_OWED = 2'b11
    } port_state_e;

    function automatic port_state_e pack_state(input logic held, input logic owed);
        port_state_e s;
        unique case ({held, owed})
            2'b00:   s = ST_FREE;
            2'b01:   s = ST_OWED;
            2'b10:   s = ST_HELD;
            default: s = ST_HELD_OWED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rrp_slot.sv
module rrp_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/rrp_ctrl.sv
module rrp_ctrl
    import rrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic fwd_accept,
    input  logic rsp_in_valid,
    input  logic rsp_accept,
    input  logic rsp_retry,
    input  logic done,
    output logic held_q,
    output logic owed_q,
    output logic sel_slot,
    output logic load_slot,
    output logic rsp_out_valid,
    output logic fwd_valid,
    output logic req_accept,
    output logic retry_pulse
);

    port_state_e state_q, state_d;

    logic held_nx, owed_mid, owed_nx, new_rsp, check, blocked;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        unique case (state_q)
            ST_FREE:      begin held_q = 1'b0; owed_q = 1'b0; end
            ST_OWED:      begin held_q = 1'b0; owed_q = 1'b1; end
            ST_HELD:      begin held_q = 1'b1; owed_q = 1'b0; end
            ST_HELD_OWED: begin held_q = 1'b1; owed_q = 1'b1; end
            default:      begin held_q = 1'b0; owed_q = 1'b0; end
        endcase

        // Response side first: a resend or a fresh response
        sel_slot      = rsp_retry & held_q;
        new_rsp       = rsp_in_valid & ~held_q;
        rsp_out_valid = sel_slot | new_rsp;
        held_nx       = rsp_out_valid ? ~rsp_accept : held_q;
        load_slot     = new_rsp & ~rsp_accept;

        // Retry check point uses the post-cycle slot state
        check       = done | sel_slot;
        retry_pulse = check & owed_q & ~held_nx;
        owed_mid    = owed_q & ~retry_pulse;

        // Request side sees the updated state
        blocked    = held_nx | owed_mid;
        fwd_valid  = req_valid & ~blocked;
        req_accept = fwd_valid & fwd_accept;
        owed_nx    = owed_mid | (req_valid & ~req_accept);

        state_d = pack_state(held_nx, owed_nx);
    end

endmodule

// File: rtl/retry_resp_port.sv
module retry_resp_port #(
    parameter int REQ_W = 32,
    parameter int RSP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [REQ_W-1:0] req_data_i,
    output logic             req_accept_o,
    output logic             fwd_valid_o,
    output logic [REQ_W-1:0] fwd_data_o,
    input  logic             fwd_accept_i,
    input  logic             rsp_valid_i,
    input  logic [RSP_W-1:0] rsp_data_i,
    output logic             rsp_valid_o,
    output logic [RSP_W-1:0] rsp_data_o,
    input  logic             rsp_accept_i,
    input  logic             rsp_retry_i,
    input  logic             resp_done_i,
    output logic             retry_o
);

    logic             held_q, owed_q, sel_slot, load_slot;
    logic [RSP_W-1:0] slot_q;

    rrp_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid_i),
        .fwd_accept   (fwd_accept_i),
        .rsp_in_valid (rsp_valid_i),
        .rsp_accept   (rsp_accept_i),
        .rsp_retry    (rsp_retry_i),
        .done         (resp_done_i),
        .held_q       (held_q),
        .owed_q       (owed_q),
        .sel_slot     (sel_slot),
        .load_slot    (load_slot),
        .rsp_out_valid(rsp_valid_o),
        .fwd_valid    (fwd_valid_o),
        .req_accept   (req_accept_o),
        .retry_pulse  (retry_o)
    );

    rrp_slot #(.W(RSP_W)) u_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_slot),
        .d    (rsp_data_i),
        .q    (slot_q)
    );

    assign fwd_data_o = req_data_i;
    assign rsp_data_o = sel_slot ? slot_q : rsp_data_i;

endmodule

// File: rtl/rrp_checks.sv
module rrp_checks #(
    parameter int REQ_W = 32,
    parameter int RSP_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [REQ_W-1:0] req_data_i,
    input logic             req_accept_o,
    input logic             fwd_valid_o,
    input logic [REQ_W-1:0] fwd_data_o,
    input logic             rsp_valid_i,
    input logic             rsp_valid_o,
    input logic             rsp_accept_i,
    input logic             rsp_retry_i,
    input logic             resp_done_i,
    input logic             retry_o,
    input logic             held_q,
    input logic             owed_q,
    input logic [RSP_W-1:0] slot_q
);

    // R8
    rsp_in_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> !held_q);

    // R2
    blocked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && held_q && !rsp_retry_i) |-> (!req_accept_o && !fwd_valid_o));

    // R3
    refuse_owes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_accept_o) |=> owed_q);

    // R4
    keep_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_accept_i) |=> held_q);

    // R5
    slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !rsp_retry_i) |=> (held_q && $stable(slot_q)));

    // R6
    retry_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> (owed_q && !(rsp_valid_o && !rsp_accept_i)));

    // R6
    retry_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> (resp_done_i || rsp_retry_i));

    // R9
    fwd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> (req_valid_i && fwd_data_o == req_data_i));

endmodule

bind retry_resp_port rrp_checks #(.REQ_W(REQ_W), .RSP_W(RSP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_data_i  (req_data_i),
    .req_accept_o(req_accept_o),
    .fwd_valid_o (fwd_valid_o),
    .fwd_data_o  (fwd_data_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_accept_i(rsp_accept_i),
    .rsp_retry_i (rsp_retry_i),
    .resp_done_i (resp_done_i),
    .retry_o     (retry_o),
    .held_q      (held_q),
    .owed_q      (owed_q),
    .slot_q      (slot_q)
);

// File: tb/test_retry_resp_port.sv
module test_retry_resp_port;

    localparam int REQ_W = 32;
    localparam int RSP_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [REQ_W-1:0] req_data_i = '0;
    logic             req_accept_o;
    logic             fwd_valid_o;
    logic [REQ_W-1:0] fwd_data_o;
    logic             fwd_accept_i = 1'b0;
    logic             rsp_valid_i = 1'b0;
    logic [RSP_W-1:0] rsp_data_i = '0;
    logic             rsp_valid_o;
    logic [RSP_W-1:0] rsp_data_o;
    logic             rsp_accept_i = 1'b0;
    logic             rsp_retry_i = 1'b0;
    logic             resp_done_i = 1'b0;
    logic             retry_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [REQ_W-1:0] exp_fwd[$];
    logic [RSP_W-1:0] exp_rsp[$];

    always #5 clk = ~clk;

    retry_resp_port #(.REQ_W(REQ_W), .RSP_W(RSP_W)) i_retry_resp_port (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus at the falling edge and queues what
    // the scoreboard must see delivered in that cycle.
    task automatic step(input logic rq, input logic [31:0] rd, input logic fa,
                        input logic rv, input logic [31:0] rsd, input logic ra,
                        input logic rr, input logic dn,
                        input logic exp_fwd_take, input logic exp_rsp_take,
                        input logic [31:0] exp_rsp_data);
        @(negedge clk);
        req_valid_i = rq; req_data_i = rd; fwd_accept_i = fa;
        rsp_valid_i = rv; rsp_data_i = rsp_data_i; rsp_data_i = rsd;
        rsp_accept_i = ra; rsp_retry_i = rr; resp_done_i = dn;
        if (exp_fwd_take) exp_fwd.push_back(rd);
        if (exp_rsp_take) exp_rsp.push_back(exp_rsp_data);
        #3;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Monitor: pops and compares every completed handshake.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && fwd_valid_o && fwd_accept_i) begin
                if (exp_fwd.size() == 0) check("R9 unexpected forward", 1, 0);
                else check("R9 forwarded payload", fwd_data_o, exp_fwd.pop_front());
            end
            if (rst_n && rsp_valid_o && rsp_accept_i) begin
                if (exp_rsp.size() == 0) check("R9 unexpected response", 1, 0);
                else check("R9 delivered response", rsp_data_o, exp_rsp.pop_front());
            end
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle();
        check("R1 retry_o after reset", retry_o, 0);
        check("R1 fwd_valid_o idle", fwd_valid_o, 0);
        check("R1 rsp_valid_o idle", rsp_valid_o, 0);

        // R9 plain request and plain response
        step(1, 32'hA1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R9 request accepted", req_accept_o, 1);
        step(0, 0, 0, 1, 32'h11, 1, 0, 0, 0, 1, 32'h11);
        check("R9 response passes through", rsp_data_o, 32'h11);
        check("R6 no pulse when nothing owed", retry_o, 0);

        // R3 downstream refusal
        step(1, 32'hA2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R3 forwarded attempt", fwd_valid_o, 1);
        check("R3 refused toward requester", req_accept_o, 0);
        // R2 owed retry blocks the next request
        step(1, 32'hA2, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R2 refused while owed", req_accept_o, 0);
        check("R2 not forwarded while owed", fwd_valid_o, 0);

        // R6 pulse on check point, then cleared
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R6 pulse on completion", retry_o, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R6 second check point silent", retry_o, 0);

        // R4 refused response is parked
        step(0, 0, 0, 1, 32'h22, 0, 0, 0, 0, 0, 0);
        check("R4 attempt shown", rsp_valid_o, 1);
        step(1, 32'hA3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R2 refused while parked", req_accept_o, 0);
        check("R2 not forwarded while parked", fwd_valid_o, 0);

        // R10 check point with slot full
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R10 no pulse while parked", retry_o, 0);

        // R5 resend refused again
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R4 resend valid", rsp_valid_o, 1);
        check("R4 resend data", rsp_data_o, 32'h22);
        check("R5 no pulse on refused resend", retry_o, 0);

        // R10/R7 resend taken with a request in the same cycle
        step(1, 32'hA4, 1, 0, 0, 1, 1, 0, 1, 1, 32'h22);
        check("R5 data kept across refusal", rsp_data_o, 32'h22);
        check("R10 pulse on drained resend", retry_o, 1);
        check("R7 request accepted with pulse", req_accept_o, 1);

        // R4 stray resend with empty slot
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R4 no phantom response", rsp_valid_o, 0);
        check("R6 no pulse after clear", retry_o, 0);

        // R9 fresh response after recovery
        step(0, 0, 0, 1, 32'h33, 1, 0, 0, 0, 1, 32'h33);
        check("R9 fresh response", rsp_data_o, 32'h33);
        idle();

        check("R9 forward queue drained", exp_fwd.size(), 0);
        check("R9 response queue drained", exp_rsp.size(), 0);
        finish_up();
    end

endmodule